// File: doc/BRIEF.md
# Self-Correcting Triple-Redundant Register

This block keeps state that must survive single-event upsets. Each protected value is stored in three separate flip-flop copies. The value the rest of the logic sees is the bitwise two-out-of-three majority of those copies. On every clock edge that carries no write, all three copies are reloaded with the voted value. A flip in one copy is therefore repaired one cycle after it appears, and the output never shows it. Whenever the copies disagree, the affected cell raises its upset flag. A sticky, saturating event counter records how many cycles had a disagreement.

The top level holds three protected cells. The first is a software-style configuration word with its own write port. The other two hold the state register and the step counter of a small sequencer. The sequencer leaves idle on a start request, counts through a fixed number of steps, passes one cycle in a done state and then returns to idle. A test-only injection port can flip any bit pattern in any one copy of any cell, so the repair path can be exercised from outside the block.

Top module: `tmr_guard_top`

## Requirements
- R1: Synchronous reset loads every copy with its reset value: `cfg_dout` = 0xA5, `seq_state` = IDLE (0), `seq_count` = 0, `upset_flags` = 0 and `upset_count` = 0 on the cycle after reset.
- R2: With `cfg_we` high at an edge, `cfg_din` goes into all three copies, so `cfg_dout` shows it after that edge with no upset flag raised.
- R3: Flipping any bit pattern in a single copy of a cell leaves that cell's voted output unchanged in every cycle.
- R4: After an edge that corrupts one copy, the cell's flag in `upset_flags` is high for that one cycle. Bit 0 is the configuration cell, bit 1 the sequencer state and bit 2 the sequencer counter.
- R5: Without a write or a further injection, the voted value is written back to all copies at the next edge, so the flag is low one cycle later.
- R6: A write at an edge takes priority over both correction and injection: the written value lands in all three copies and no disagreement follows.
- R7: `upset_count` rises by one at each edge where any flag is high, and it holds at its all-ones maximum (255) once it gets there.
- R8: `upset_count` is cleared only by reset. Configuration writes and sequencer activity leave it unchanged.
- R9: Sequencer encodings are IDLE=0, RUN=1, DONE=2. `seq_go` in IDLE moves to RUN with count 0. In RUN the count steps by one per cycle up to 5, then the state becomes DONE with the count held at 5. DONE returns to IDLE with count 0 after one cycle.
- R10: `seq_go` has no effect outside IDLE. The RUN and DONE progression is the same whether it is high or low.
- R11: An upset in one copy of the sequencer state while in IDLE neither starts nor changes the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write enable for the configuration cell |
| cfg_din | input | 8 | Data written to the configuration cell |
| seq_go | input | 1 | Start request for the sequencer |
| inj_en | input | 1 | Test-only: apply an upset at this edge |
| inj_target | input | 2 | Test-only: 0 config, 1 sequencer state, 2 sequencer counter, 3 none |
| inj_copy | input | 2 | Test-only: copy index 0..2 to corrupt |
| inj_mask | input | 8 | Test-only: bits to flip (low bits used by narrower cells) |
| cfg_dout | output | 8 | Voted configuration value |
| seq_state | output | 2 | Voted sequencer state |
| seq_count | output | 4 | Voted sequencer step counter |
| upset_flags | output | 3 | Per-cell copy-disagreement flags |
| upset_count | output | 8 | Sticky saturating count of cycles with any disagreement |

## Verification
On every cycle, the in-line properties check these cell behaviours: the voted output holds steady across an edge without a write, a write appears in the next cycle with the copies in agreement, and a clean edge leaves the copies agreeing. They also check that the sequencer's RUN and DONE steps ignore the start input and that the event counter only moves on a flagged cycle and stays put at saturation. Only the directed scenarios can show the rest: the exact reset values, which flag bit belongs to which cell, the event tally across a mix of injections and writes, the complete step-by-step sequence, and a state upset in IDLE failing to start a run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned N_COPIES = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        TGT_CFG   = 2'd0,
        TGT_STATE = 2'd1,
        TGT_COUNT = 2'd2,
        TGT_NONE  = 2'd3
    } inj_target_e;

    // two-out-of-three majority of one bit
    function automatic logic maj_bit(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // high when the three copies of one bit are not all equal
    function automatic logic split_bit(input logic a, input logic b, input logic c);
        return (a ^ b) | (a ^ c);
    endfunction

endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] c0,
    input  logic [W-1:0] c1,
    input  logic [W-1:0] c2,
    output logic [W-1:0] voted,
    output logic         mismatch
);
    logic [W-1:0] split;

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            assign voted[b] = tmr_pkg::maj_bit(c0[b], c1[b], c2[b]);
            assign split[b] = tmr_pkg::split_bit(c0[b], c1[b], c2[b]);
        end
    endgenerate

    assign mismatch = |split;
endmodule

// File: rtl/tmr_reg.sv
module tmr_reg #(
    parameter int unsigned   W       = 8,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    input  logic         flip_en,
    input  logic [1:0]   flip_copy,
    input  logic [W-1:0] flip_mask,
    output logic [W-1:0] q,
    output logic         err
);
    logic [W-1:0] copies [tmr_pkg::N_COPIES];

    generate
        for (genvar k = 0; k < tmr_pkg::N_COPIES; k++) begin : g_copy
            logic [W-1:0] cq;
            always_ff @(posedge clk) begin
                if (rst)
                    cq <= RST_VAL;
                else if (we)
                    cq <= d;
                else if (flip_en && (flip_copy == 2'(k)))
                    cq <= q ^ flip_mask;
                else
                    cq <= q;
            end
            assign copies[k] = cq;
        end
    endgenerate

    tmr_voter #(.W(W)) u_voter (
        .c0       (copies[0]),
        .c1       (copies[1]),
        .c2       (copies[2]),
        .voted    (q),
        .mismatch (err)
    );

    // R2: a write shows up next cycle with copies in agreement
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(d)) && !err);

    // R3: without a write the voted value never moves
    p_vote_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !we |=> (q == $past(q)));

    // R4: a real single-copy upset is flagged in the following cycle
    p_flag_raise_r4: assert property (@(posedge clk) disable iff (rst)
        (!we && flip_en && (flip_copy < 2'd3) && (|flip_mask)) |=> err);

    // R5: a clean edge leaves all copies equal
    p_repair_r5: assert property (@(posedge clk) disable iff (rst)
        (!we && !flip_en) |=> !err);
endmodule

// File: rtl/tmr_upset_counter.sv
module tmr_upset_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         event_in,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (event_in && (count != CNT_MAX))
            count <= count + W'(1);
    end

    // R7: saturated value is held
    p_saturate_r7: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_MAX) |=> (count == CNT_MAX));

    // R8: no event, no change
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !event_in |=> $stable(count));
endmodule

// File: rtl/tmr_seq.sv
module tmr_seq #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned LAST  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             st_flip_en,
    input  logic             cnt_flip_en,
    input  logic [1:0]       flip_copy,
    input  logic [1:0]       st_mask,
    input  logic [CNT_W-1:0] cnt_mask,
    output logic [1:0]       state,
    output logic [CNT_W-1:0] count,
    output logic             st_err,
    output logic             cnt_err
);
    import tmr_pkg::*;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAST);

    seq_state_e       st_v;
    seq_state_e       st_n;
    logic [CNT_W-1:0] cnt_n;
    logic             st_we;
    logic             cnt_we;

    assign st_v = seq_state_e'(state);

    always_comb begin
        st_n  = st_v;
        cnt_n = count;
        case (st_v)
            SEQ_IDLE: begin
                cnt_n = '0;
                if (go) st_n = SEQ_RUN;
            end
            SEQ_RUN: begin
                if (count == CNT_LAST) st_n = SEQ_DONE;
                else                   cnt_n = count + CNT_W'(1);
            end
            SEQ_DONE: begin
                st_n  = SEQ_IDLE;
                cnt_n = '0;
            end
            default: begin
                st_n  = SEQ_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    // write only on change so idle cycles are scrub cycles
    assign st_we  = (st_n != st_v);
    assign cnt_we = (cnt_n != count);

    tmr_reg #(.W(2), .RST_VAL(2'(SEQ_IDLE))) u_state (
        .clk       (clk),
        .rst       (rst),
        .we        (st_we),
        .d         (2'(st_n)),
        .flip_en   (st_flip_en),
        .flip_copy (flip_copy),
        .flip_mask (st_mask),
        .q         (state),
        .err       (st_err)
    );

    tmr_reg #(.W(CNT_W), .RST_VAL('0)) u_count (
        .clk       (clk),
        .rst       (rst),
        .we        (cnt_we),
        .d         (cnt_n),
        .flip_en   (cnt_flip_en),
        .flip_copy (flip_copy),
        .flip_mask (cnt_mask),
        .q         (count),
        .err       (cnt_err)
    );

    // R9: DONE lasts one cycle and returns to IDLE with a cleared count
    p_done_return_r9: assert property (@(posedge clk) disable iff (rst)
        (st_v == SEQ_DONE) |=> (st_v == SEQ_IDLE) && (count == '0));

    // R10: RUN is not disturbed by the start input
    p_run_ignores_go_r10: assert property (@(posedge clk) disable iff (rst)
        (st_v == SEQ_RUN && count != CNT_LAST) |=> (st_v == SEQ_RUN));
endmodule

// File: rtl/tmr_guard_top.sv
module tmr_guard_top #(
    parameter int unsigned        DATA_W    = 8,
    parameter logic [DATA_W-1:0]  CFG_RST   = 8'hA5,
    parameter int unsigned        SEQ_CNT_W = 4,
    parameter int unsigned        SEQ_LAST  = 5,
    parameter int unsigned        ERR_CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [DATA_W-1:0]    cfg_din,
    input  logic                 seq_go,
    input  logic                 inj_en,
    input  logic [1:0]           inj_target,
    input  logic [1:0]           inj_copy,
    input  logic [DATA_W-1:0]    inj_mask,
    output logic [DATA_W-1:0]    cfg_dout,
    output logic [1:0]           seq_state,
    output logic [SEQ_CNT_W-1:0] seq_count,
    output logic [2:0]           upset_flags,
    output logic [ERR_CNT_W-1:0] upset_count
);
    import tmr_pkg::*;

    localparam int unsigned N_CELLS = 3;

    logic [N_CELLS-1:0] hit;
    logic               cfg_err;
    logic               st_err;
    logic               cnt_err;

    generate
        for (genvar t = 0; t < N_CELLS; t++) begin : g_sel
            assign hit[t] = inj_en && (inj_target == 2'(t));
        end
    endgenerate

    tmr_reg #(.W(DATA_W), .RST_VAL(CFG_RST)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .d         (cfg_din),
        .flip_en   (hit[TGT_CFG]),
        .flip_copy (inj_copy),
        .flip_mask (inj_mask),
        .q         (cfg_dout),
        .err       (cfg_err)
    );

    tmr_seq #(.CNT_W(SEQ_CNT_W), .LAST(SEQ_LAST)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .go          (seq_go),
        .st_flip_en  (hit[TGT_STATE]),
        .cnt_flip_en (hit[TGT_COUNT]),
        .flip_copy   (inj_copy),
        .st_mask     (inj_mask[1:0]),
        .cnt_mask    (inj_mask[SEQ_CNT_W-1:0]),
        .state       (seq_state),
        .count       (seq_count),
        .st_err      (st_err),
        .cnt_err     (cnt_err)
    );

    assign upset_flags = {cnt_err, st_err, cfg_err};

    tmr_upset_counter #(.W(ERR_CNT_W)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .event_in (|upset_flags),
        .count    (upset_count)
    );

    // R11: a state upset in IDLE does not start the sequence
    p_idle_upset_r11: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd0 && !seq_go) |=> (seq_state == 2'd0));
endmodule

// File: tb/tmr_guard_top_tb.sv
`timescale 1ns/1ps
module tmr_guard_top_tb;
    localparam int LAST = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [7:0] cfg_din;
    logic       seq_go;
    logic       inj_en;
    logic [1:0] inj_target;
    logic [1:0] inj_copy;
    logic [7:0] inj_mask;
    logic [7:0] cfg_dout;
    logic [1:0] seq_state;
    logic [3:0] seq_count;
    logic [2:0] upset_flags;
    logic [7:0] upset_count;

    int checks   = 0;
    int failures = 0;
    int exp_cnt  = 0;
    logic [7:0] exp_cfg;

    always #10 clk = ~clk;

    tmr_guard_top u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_din(cfg_din),
        .seq_go(seq_go), .inj_en(inj_en), .inj_target(inj_target),
        .inj_copy(inj_copy), .inj_mask(inj_mask), .cfg_dout(cfg_dout),
        .seq_state(seq_state), .seq_count(seq_count),
        .upset_flags(upset_flags), .upset_count(upset_count)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bump();
        if (exp_cnt < 255) exp_cnt++;
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_we = 0; cfg_din = 0; seq_go = 0;
        inj_en = 0; inj_target = 2'd3; inj_copy = 0; inj_mask = 0;
        tick(); tick();
        rst = 1'b0;
        exp_cnt = 0;
        exp_cfg = 8'hA5;
        check("R1", "cfg_dout", cfg_dout, 8'hA5);
        check("R1", "seq_state", seq_state, 0);
        check("R1", "seq_count", seq_count, 0);
        check("R1", "upset_flags", upset_flags, 0);
        check("R1", "upset_count", upset_count, 0);
    endtask

    task automatic t_write(input logic [7:0] v);
        cfg_we = 1; cfg_din = v;
        tick();
        cfg_we = 0;
        exp_cfg = v;
        check("R2", "cfg_dout after write", cfg_dout, v);
        check("R2", "no flag after write", upset_flags, 0);
        check("R8", "count unchanged by write", upset_count, exp_cnt);
    endtask

    // one upset, then one clean cycle
    task automatic t_inject(input logic [1:0] tgt, input logic [1:0] cp,
                            input logic [7:0] m, input logic [2:0] exp_flag);
        logic [1:0] st0;
        logic [3:0] c0;
        st0 = seq_state; c0 = seq_count;
        inj_en = 1; inj_target = tgt; inj_copy = cp; inj_mask = m;
        tick();
        inj_en = 0; inj_target = 2'd3; inj_mask = 0;
        check("R3", "cfg held under upset", cfg_dout, exp_cfg);
        check("R11", "state held under upset", seq_state, st0);
        check("R3", "count held under upset", seq_count, c0);
        check("R4", "flag raised", upset_flags, exp_flag);
        tick();
        bump();
        check("R5", "flag cleared after repair", upset_flags, 0);
        check("R3", "cfg after repair", cfg_dout, exp_cfg);
        check("R7", "upset_count", upset_count, exp_cnt);
    endtask

    task automatic t_write_wins();
        cfg_we = 1; cfg_din = 8'h5A;
        inj_en = 1; inj_target = 2'd0; inj_copy = 2'd0; inj_mask = 8'hFF;
        tick();
        cfg_we = 0; inj_en = 0; inj_target = 2'd3; inj_mask = 0;
        exp_cfg = 8'h5A;
        check("R6", "written value", cfg_dout, 8'h5A);
        check("R6", "no disagreement", upset_flags, 0);
        tick();
        check("R6", "count unchanged", upset_count, exp_cnt);
    endtask

    task automatic t_sequence(input logic hold_go);
        seq_go = 1;
        tick();
        seq_go = hold_go;
        check("R9", "enter RUN", seq_state, 1);
        check("R9", "RUN count start", seq_count, 0);
        for (int i = 1; i <= LAST; i++) begin
            tick();
            check("R10", "still RUN", seq_state, 1);
            check("R9", "RUN step", seq_count, i);
        end
        tick();
        check("R9", "DONE", seq_state, 2);
        check("R9", "DONE count held", seq_count, LAST);
        seq_go = 0;
        tick();
        check("R9", "back to IDLE", seq_state, 0);
        check("R9", "IDLE count", seq_count, 0);
        check("R8", "count unchanged by sequence", upset_count, exp_cnt);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 300; i++) begin
            inj_en = 1; inj_target = 2'd0; inj_copy = 2'(i % 3); inj_mask = 8'(i + 1);
            tick();
            inj_en = 0; inj_target = 2'd3; inj_mask = 0;
            tick();
            bump();
        end
        check("R7", "saturated count", upset_count, 255);
        check("R3", "cfg after many upsets", cfg_dout, exp_cfg);
        t_inject(2'd1, 2'd2, 8'h02, 3'b010);
        check("R7", "stays saturated", upset_count, 255);
        rst = 1;
        tick();
        rst = 0;
        exp_cnt = 0;
        check("R8", "reset clears count", upset_count, 0);
        check("R1", "reset cfg", cfg_dout, 8'hA5);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_write(8'h3C);
        t_inject(2'd0, 2'd0, 8'h01, 3'b001);
        t_inject(2'd0, 2'd1, 8'hFF, 3'b001);
        t_inject(2'd0, 2'd2, 8'h80, 3'b001);
        t_inject(2'd1, 2'd1, 8'h01, 3'b010);
        t_inject(2'd1, 2'd0, 8'h03, 3'b010);
        t_inject(2'd2, 2'd2, 8'h08, 3'b100);
        t_write_wins();
        t_sequence(1'b0);
        t_sequence(1'b1);
        t_write(8'h00);
        t_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule